// File: doc/BRIEF.md
# Memory-Mapped Event Counter Group

This block holds a parameterised set of event counters that software reaches through a flat register window with a 12-bit byte address. Each counter picks one event by number from its own selection register and advances by one on every clock edge where the event is present. It also needs its per-counter enable, the global count enable and an externally supplied per-counter filter qualifier. A counter wraps to zero past its all-ones value and latches a sticky overflow flag. A single level interrupt is raised while any overflowed counter has its interrupt enabled and the interrupt gate is open.

Counter enable, interrupt enable and overflow state are never written directly. Each is changed through a write-one-to-set location and a write-one-to-clear location, so several agents can manipulate individual counters without a read-modify-write. Fixed read-only words report the counter count and width and which events are implemented. Writes take effect at the clock edge that samples them. Read data is a combinational function of the read address.

Top module: `perf_ctr_group`

## Requirements
- R1: After reset every counter, enable mask, interrupt-enable mask, overflow flag, selection word, pattern word, global count enable and interrupt gate reads zero, and `irqOut` is low.
- R2: The word at 0xE00 reads NUM_CTR-1 in bits 5:0, CTR_W-1 in bits 13:8 and GLOBAL_FILT in bit 23, with bit 20 and all other bits zero. The word at 0xE20 reads EVT_MASK zero-extended (bit k set means event k is implemented), and 0xE28 reads zero.
- R3: Counter n sits at byte address n*4 when CTR_W is at most 32 and n*8 otherwise. A write stores the low CTR_W bits, and a read returns the value zero-extended. Addresses that map to nothing read zero and writes to them change nothing.
- R4: Writing 0xC00 sets the enable bits where the data has ones, and writing 0xC20 clears them. Zero bits leave enables unchanged and both addresses read the enable mask. 0xC40 and 0xC60 behave the same way for the interrupt-enable mask.
- R5: Counter n advances by one at an edge only when all of these hold: bit 0 of 0xE04 is set, enable bit n is set, `filterHit[n]` is high and its selected event is active. Event number 0 is active every cycle. Event k from 1 to NUM_EVT-1 is active when `evIn[k]` is high. An event whose EVT_MASK bit is clear, or whose number is NUM_EVT or more, never counts.
- R6: The selection word of counter n at 0x400+4n keeps the event number in bits 15:0 and a span flag in bit 29, and reads zero elsewhere. The 32-bit pattern word of counter n at 0xA00+4n reads back as written.
- R7: A counter that advances from all ones wraps to zero and sets overflow bit n at the same edge.
- R8: Writing ones to 0xC80 clears overflow bits and writing ones to 0xCC0 sets them, and both addresses read the overflow flags. A wrap at the same edge as a clear of that bit leaves the bit set.
- R9: `irqOut` is high exactly when bit 0 of 0xE50 is set and some counter has both its overflow flag and its interrupt-enable bit set. It follows register changes with no added delay.
- R10: A software write to a counter at the same edge as a qualified increment stores the written value. The increment is dropped and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 12 | Write byte address |
| wrData | input | 64 | Write data |
| rdAddr | input | 12 | Read byte address |
| rdData | output | 64 | Read data, combinational from rdAddr |
| evIn | input | NUM_EVT | Event inputs; bit 0 unused because event 0 is every cycle |
| filterHit | input | NUM_CTR | Per-counter filter qualifier from outside the block |
| irqOut | output | 1 | Level overflow interrupt |

## Verification
A corrupted enable, selection or filter path shows at the counter read port after a single counting window, because the count differs from the window length or from zero. A broken wrap or overflow flag shows at once at `irqOut` and in the 0xCC0 word in the cycle after the wrapping edge. A wrong priority between a software write and an increment leaves the counter one step off, or sets a stray overflow bit, both readable on the next cycle. The bench drives windows of known length across every event number, including unimplemented ones, and under a mix of filter and enable patterns, then computes each expected count from the window length.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int MAX_CTR = 64;

  localparam logic [11:0] A_CFG     = 12'hE00;
  localparam logic [11:0] A_CTRL    = 12'hE04;
  localparam logic [11:0] A_EVID_LO = 12'hE20;
  localparam logic [11:0] A_EVID_HI = 12'hE28;
  localparam logic [11:0] A_IRQ     = 12'hE50;
  localparam logic [11:0] A_CEN_SET = 12'hC00;
  localparam logic [11:0] A_CEN_CLR = 12'hC20;
  localparam logic [11:0] A_IEN_SET = 12'hC40;
  localparam logic [11:0] A_IEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR = 12'hC80;
  localparam logic [11:0] A_OVF_SET = 12'hCC0;
  localparam int          EVT_BASE  = 'h400;
  localparam int          PAT_BASE  = 'hA00;

  // strobes from control to datapath
  typedef struct packed {
    logic [MAX_CTR-1:0] wrMask;
    logic [MAX_CTR-1:0] incMask;
    logic [63:0]        wrData;
  } pcg_strb_t;
endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int                 NUM_CTR     = 8,
  parameter int                 CTR_W       = 32,
  parameter int                 NUM_EVT     = 8,
  parameter logic [NUM_EVT-1:0] EVT_MASK    = '1,
  parameter bit                 GLOBAL_FILT = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [11:0]              wrAddr,
  input  logic [63:0]              wrData,
  input  logic [11:0]              rdAddr,
  output logic [63:0]              rdData,
  input  logic [NUM_EVT-1:0]       evIn,
  input  logic [NUM_CTR-1:0]       filterHit,
  input  logic [NUM_CTR*CTR_W-1:0] ctrFlat,
  input  logic [NUM_CTR-1:0]       wrapVec,
  output pcg_strb_t                strb,
  output logic [NUM_CTR-1:0]       ovfQ,
  output logic [NUM_CTR-1:0]       intEnQ,
  output logic                     irqGateQ
);
  localparam int STRIDE = (CTR_W > 32) ? 8 : 4;
  localparam int EVT_IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [63:0] CFG_VAL = (64'(GLOBAL_FILT) << 23)
                                  | (64'(CTR_W - 1) << 8)
                                  | 64'(NUM_CTR - 1);

  logic               crEn;
  logic [NUM_CTR-1:0] cntEn;
  logic [16:0]        evType [NUM_CTR];
  logic [31:0]        patWord [NUM_CTR];
  logic [NUM_CTR-1:0] evAct;
  logic [NUM_CTR-1:0] ovfClr, ovfSet, ovfNext;
  logic [EVT_IW-1:0]  evIdx;

  // event selection per counter
  always_comb begin
    evAct = '0;
    evIdx = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (evType[n][15:0] < 16'(NUM_EVT)) begin
        evIdx = evType[n][EVT_IW-1:0];
        if (EVT_MASK[evIdx]) evAct[n] = (evIdx == '0) ? 1'b1 : evIn[evIdx];
      end
    end
  end

  // strobes: a software write blocks the increment of the same counter
  always_comb begin
    strb = '0;
    strb.wrData = wrData;
    for (int n = 0; n < NUM_CTR; n++) begin
      strb.wrMask[n]  = wrEn && (wrAddr == 12'(n * STRIDE));
      strb.incMask[n] = crEn && cntEn[n] && filterHit[n] && evAct[n]
                        && !strb.wrMask[n];
    end
  end

  always_comb begin
    ovfClr  = (wrEn && wrAddr == A_OVF_CLR) ? wrData[NUM_CTR-1:0] : '0;
    ovfSet  = (wrEn && wrAddr == A_OVF_SET) ? wrData[NUM_CTR-1:0] : '0;
    ovfNext = (ovfQ & ~ovfClr) | ovfSet | wrapVec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crEn     <= 1'b0;
      irqGateQ <= 1'b0;
      cntEn    <= '0;
      intEnQ   <= '0;
      ovfQ     <= '0;
      for (int n = 0; n < NUM_CTR; n++) begin
        evType[n]  <= '0;
        patWord[n] <= '0;
      end
    end else begin
      if (wrEn) begin
        case (wrAddr)
          A_CTRL:    crEn     <= wrData[0];
          A_IRQ:     irqGateQ <= wrData[0];
          A_CEN_SET: cntEn    <= cntEn | wrData[NUM_CTR-1:0];
          A_CEN_CLR: cntEn    <= cntEn & ~wrData[NUM_CTR-1:0];
          A_IEN_SET: intEnQ   <= intEnQ | wrData[NUM_CTR-1:0];
          A_IEN_CLR: intEnQ   <= intEnQ & ~wrData[NUM_CTR-1:0];
          default: ;
        endcase
        for (int n = 0; n < NUM_CTR; n++) begin
          if (wrAddr == 12'(EVT_BASE + 4 * n)) evType[n]  <= {wrData[29], wrData[15:0]};
          if (wrAddr == 12'(PAT_BASE + 4 * n)) patWord[n] <= wrData[31:0];
        end
      end
      ovfQ <= ovfNext;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CFG:                rdData = CFG_VAL;
      A_CTRL:               rdData = 64'(crEn);
      A_IRQ:                rdData = 64'(irqGateQ);
      A_EVID_LO:            rdData = 64'(EVT_MASK);
      A_CEN_SET, A_CEN_CLR: rdData = 64'(cntEn);
      A_IEN_SET, A_IEN_CLR: rdData = 64'(intEnQ);
      A_OVF_SET, A_OVF_CLR: rdData = 64'(ovfQ);
      default: ;
    endcase
    for (int n = 0; n < NUM_CTR; n++) begin
      if (rdAddr == 12'(n * STRIDE))       rdData = 64'(ctrFlat[n*CTR_W +: CTR_W]);
      if (rdAddr == 12'(EVT_BASE + 4 * n)) rdData = 64'({evType[n][16], 13'b0, evType[n][15:0]});
      if (rdAddr == 12'(PAT_BASE + 4 * n)) rdData = 64'(patWord[n]);
    end
  end
endmodule

// File: rtl/pcg_datapath.sv
module pcg_datapath
  import pcg_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pcg_strb_t                strb,
  output logic [NUM_CTR*CTR_W-1:0] ctrFlat,
  output logic [NUM_CTR-1:0]       wrapVec
);
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic [CTR_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst)                  cnt <= '0;
      else if (strb.wrMask[n])  cnt <= strb.wrData[CTR_W-1:0];
      else if (strb.incMask[n]) cnt <= cnt + 1'b1;
    end

    assign ctrFlat[n*CTR_W +: CTR_W] = cnt;
    assign wrapVec[n] = strb.incMask[n] && (&cnt);
  end
endmodule

// File: rtl/perf_ctr_group.sv
module perf_ctr_group
  import pcg_pkg::*;
#(
  parameter int                 NUM_CTR     = 8,
  parameter int                 CTR_W       = 32,
  parameter int                 NUM_EVT     = 8,
  parameter logic [NUM_EVT-1:0] EVT_MASK    = '1,
  parameter bit                 GLOBAL_FILT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [11:0]        wrAddr,
  input  logic [63:0]        wrData,
  input  logic [11:0]        rdAddr,
  output logic [63:0]        rdData,
  input  logic [NUM_EVT-1:0] evIn,
  input  logic [NUM_CTR-1:0] filterHit,
  output logic               irqOut
);
  pcg_strb_t                strb;
  logic [NUM_CTR*CTR_W-1:0] ctrFlat;
  logic [NUM_CTR-1:0]       wrapVec;
  logic [NUM_CTR-1:0]       ovfQ;
  logic [NUM_CTR-1:0]       intEnQ;
  logic                     irqGateQ;

  pcg_ctrl #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .NUM_EVT(NUM_EVT),
    .EVT_MASK(EVT_MASK), .GLOBAL_FILT(GLOBAL_FILT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evIn(evIn), .filterHit(filterHit),
    .ctrFlat(ctrFlat), .wrapVec(wrapVec), .strb(strb), .ovfQ(ovfQ),
    .intEnQ(intEnQ), .irqGateQ(irqGateQ)
  );

  pcg_datapath #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .ctrFlat(ctrFlat), .wrapVec(wrapVec)
  );

  assign irqOut = irqGateQ && (|(ovfQ & intEnQ));
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import pcg_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wrEn,
  input logic [11:0]              wrAddr,
  input pcg_strb_t                strb,
  input logic [NUM_CTR-1:0]       wrapVec,
  input logic [NUM_CTR-1:0]       ovfQ,
  input logic [NUM_CTR*CTR_W-1:0] ctrFlat,
  input logic                     irqOut
);
  // R10: never a write and an increment to the same counter together
  a_r10_write_beats_inc: assert property (@(posedge clk) disable iff (rst)
    (strb.wrMask[NUM_CTR-1:0] & strb.incMask[NUM_CTR-1:0]) == '0);

  // R3: a software write to counter 0 lands at the next edge
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    strb.wrMask[0] |=> (ctrFlat[CTR_W-1:0] == $past(strb.wrData[CTR_W-1:0])));

  // R7: a wrap leaves the overflow flag set
  a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (|wrapVec) |=> ((ovfQ & $past(wrapVec)) == $past(wrapVec)));

  // R8: overflow flags only fall after a clear write
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    !($past(wrEn) && ($past(wrAddr) == A_OVF_CLR)) |->
      ((ovfQ & $past(ovfQ)) == $past(ovfQ)));

  // R9: the interrupt needs a pending overflow
  a_r9_irq_needs_ovf: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (|ovfQ));
endmodule

bind perf_ctr_group pcg_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb),
  .wrapVec(wrapVec), .ovfQ(ovfQ), .ctrFlat(ctrFlat), .irqOut(irqOut)
);

// File: tb/perf_ctr_group_tb_top.sv
`timescale 1ns/1ps
module perf_ctr_group_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [63:0] rdData, rdData8;
  logic [7:0]  evIn = '0;
  logic [3:0]  filterHit = '0;
  logic        irqOut, irqOut8;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  perf_ctr_group #(.NUM_CTR(4), .CTR_W(8), .NUM_EVT(8), .EVT_MASK(8'h7F),
                   .GLOBAL_FILT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evIn(evIn), .filterHit(filterHit),
    .irqOut(irqOut));

  perf_ctr_group #(.NUM_CTR(2), .CTR_W(40)) dut8_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData8), .evIn(evIn), .filterHit(2'b00),
    .irqOut(irqOut8));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdc(input string req, input logic [11:0] a, input logic [63:0] exp);
    rdAddr = a; #1;
    chk(req, rdData, exp);
  endtask

  task automatic rdc8(input string req, input logic [11:0] a, input logic [63:0] exp);
    rdAddr = a; #1;
    chk(req, rdData8, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rdc("R1 ctrl", 12'hE04, 0);
    rdc("R1 enable", 12'hC00, 0);
    rdc("R1 ovf", 12'hCC0, 0);
    rdc("R1 ctr0", 12'h000, 0);
    rdc("R1 evtype0", 12'h400, 0);
    rdc("R1 pattern0", 12'hA00, 0);
    rdc("R1 irq gate", 12'hE50, 0);
    chk("R1 irqOut", 64'(irqOut), 0);

    // R2 identification words
    rdc("R2 cfg", 12'hE00, 64'h0080_0703);
    rdc("R2 evid lo", 12'hE20, 64'h7F);
    rdc("R2 evid hi", 12'hE28, 0);
    rdc8("R2 cfg wide", 12'hE00, 64'h2701);

    // R3 wide counters on an 8-byte stride
    wr(12'h008, 64'h12_3456_789A);
    rdc8("R3 wide ctr1", 12'h008, 64'h12_3456_789A);
    rdc8("R3 wide gap", 12'h004, 0);

    // R3 narrow counters on a 4-byte stride, upper data dropped
    for (int n = 0; n < 4; n++) wr(12'(4 * n), 64'hFFFF_FF00 | 64'((n * 37 + 11) & 'hFF));
    for (int n = 0; n < 4; n++) rdc("R3 ctr readback", 12'(4 * n), 64'((n * 37 + 11) & 'hFF));
    wr(12'h900, 64'h5);
    rdc("R3 unmapped", 12'h900, 0);
    rdc("R3 beyond last", 12'h010, 0);

    // R4 set/clear masks
    wr(12'hC00, 5);  rdc("R4 set", 12'hC00, 5); rdc("R4 clr alias", 12'hC20, 5);
    wr(12'hC00, 2);  rdc("R4 set keeps", 12'hC00, 7);
    wr(12'hC20, 4);  rdc("R4 clr", 12'hC00, 3);
    wr(12'hC40, 10); wr(12'hC60, 8); rdc("R4 int en", 12'hC40, 2);
    wr(12'hC60, 2);  rdc("R4 int en clr", 12'hC60, 0);

    // R6 selection and pattern words
    wr(12'h408, 64'hFFFF_FFFF_FFFF_FFFF);
    rdc("R6 evtype fields", 12'h408, 64'h2000_FFFF);
    wr(12'hA04, 64'h1_DEAD_BEEF);
    rdc("R6 pattern", 12'hA04, 64'hDEAD_BEEF);

    // R5 global gate closed
    for (int n = 0; n < 4; n++) wr(12'(12'h400 + 4 * n), 0);
    for (int n = 0; n < 4; n++) wr(12'(4 * n), 0);
    filterHit = 4'hF;
    wr(12'hC00, 15);
    repeat (5) @(negedge clk);
    for (int n = 0; n < 4; n++) rdc("R5 gate off", 12'(4 * n), 0);
    wr(12'hE04, 1); rdc("R5 ctrl read", 12'hE04, 1); wr(12'hE04, 0);
    for (int n = 0; n < 4; n++) wr(12'(4 * n), 0);

    // R5 event sweep with counter 2 disabled
    wr(12'hC20, 4);
    for (int sel = 0; sel < 10; sel++) begin
      int g;
      logic qual;
      for (int n = 0; n < 4; n++) wr(12'(12'h400 + 4 * n), 64'(sel));
      for (int n = 0; n < 4; n++) wr(12'(4 * n), 0);
      evIn = 8'hA5 ^ 8'(sel * 'h3C);
      filterHit = 4'((sel * 3 + 5) & 'hF);
      g = 2 + sel % 3;
      wr(12'hE04, 1);
      repeat (g) @(negedge clk);
      wr(12'hE04, 0);
      qual = (sel == 0) || (sel < 7 && evIn[sel]);
      for (int n = 0; n < 4; n++)
        rdc($sformatf("R5 sel=%0d ctr=%0d", sel, n), 12'(4 * n),
            (qual && filterHit[n] && n != 2) ? 64'(g + 1) : 0);
    end

    // R7 wrap and R9 interrupt
    for (int n = 0; n < 4; n++) wr(12'(12'h400 + 4 * n), 0);
    filterHit = 4'hF;
    wr(12'hC20, 15); wr(12'hC00, 2);
    wr(12'h004, 8'hFE);
    wr(12'hC40, 2); wr(12'hE50, 1);
    chk("R9 no ovf no irq", 64'(irqOut), 0);
    wr(12'hE04, 1); @(negedge clk); wr(12'hE04, 0);
    rdc("R7 wrapped value", 12'h004, 0);
    rdc("R7 ovf flag", 12'hCC0, 2);
    chk("R9 irq high", 64'(irqOut), 1);
    wr(12'hC60, 2); chk("R9 int en off", 64'(irqOut), 0);
    wr(12'hC40, 2); chk("R9 int en on", 64'(irqOut), 1);
    wr(12'hE50, 0); chk("R9 gate off", 64'(irqOut), 0);

    // R8 clear/set
    wr(12'hC80, 2); rdc("R8 clear", 12'hCC0, 0);
    wr(12'hCC0, 8); rdc("R8 set via alias", 12'hC80, 8);
    wr(12'hC80, 8);
    wr(12'h004, 8'hFF);
    wr(12'hE04, 1); wr(12'hC80, 2); wr(12'hE04, 0);
    rdc("R8 wrap beats clear", 12'hCC0, 2);
    rdc("R8 counter after", 12'h004, 1);

    // R10 software write wins
    wr(12'hC80, 15); wr(12'hC20, 15); wr(12'hC00, 8);
    wr(12'h00C, 8'hFF);
    wr(12'hE04, 1); wr(12'h00C, 8'h10); wr(12'hE04, 0);
    rdc("R10 write wins", 12'h00C, 8'h11);
    rdc("R10 no overflow", 12'hCC0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule